// File: doc/BRIEF.md
# Eight-bit Multi-Mode Timer with Waveform Output

This block is an 8-bit timer that counts on a clock enable taken from its own free-running prescaler. It has one compare channel and drives one waveform pin. Software reaches four registers through a simple write port and a combinational read port. The registers are a control register, the live count, the compare value and a flag register. The mode field picks one of four counting schemes:
- free-running wrap,
- clear-on-compare,
- single-slope (fast) PWM,
- dual-slope (phase-correct) PWM.

The output-mode field picks what the pin does on a compare match and at the top of the count.

A single compare unit serves every mode. In the two PWM modes the compare value written by software sits in a buffer. It reaches the comparator only when the count passes 0xFF, which keeps each PWM period glitch-free. The overflow flag and the compare flag are sticky and are cleared by writing ones. A force bit in the control word applies the non-PWM pin action at once, as though a match had happened. It raises no flag and leaves the count alone.

Counting direction is held in a two-state machine with the states DIR_UP and DIR_DOWN:
- Transition UP_TO_DOWN is taken on a dual-slope tick at count 0xFF.
- Transition DOWN_TO_UP is taken on a dual-slope tick at count 0x00.
- Transition FORCE_UP returns the machine to DIR_UP in any cycle where the mode is not dual-slope.

The pin is a second two-state machine with the states PIN_LO and PIN_HI. Its transitions are SET, CLEAR and FLIP, or no change. The pin-action logic of the active mode selects which one is taken.

Top module: `pwm_timer8`

## Requirements
- R1: After reset every register, the prescaler, both flags, the pin and the output enable are zero, and the direction state is DIR_UP.
- R2: Clock select (control bits 2:0) 000 stops the counter. Code 001 ticks every cycle. Codes 010 to 111 tick once every 8, 32, 64, 128, 256 and 1024 cycles, when the low bits of a shared 10-bit free-running prescaler are all ones.
- R3: In mode 00 (control bits 6:5) the count goes up by one per tick and wraps from 0xFF to 0x00. The overflow flag (flag bit 0) is set on the tick that leaves 0xFF.
- R4: In mode 10 the tick on which the count equals the compare value takes the count to 0x00. The overflow flag is set only on a tick leaving 0xFF.
- R5: The compare flag (flag bit 1) is set on any tick on which the count before the tick equals the active compare value. Writing a one to a flag bit at address 3 clears it. A set in the same cycle wins over the clear.
- R6: In modes 00 and 10 a match applies the action selected by the output mode (control bits 4:3): 00 none, 01 flip, 10 drive low, 11 drive high.
- R7: In mode 11 (single slope) output mode 10 drives the pin low on match and high on the tick leaving 0xFF. Output mode 11 does the inverse. Output mode 01 leaves the pin unchanged.
- R8: In mode 01 (dual slope) the count runs 0 up to 0xFF and back down to 0. Each end value lasts one tick. The overflow flag is set on the tick that leaves 0x00 while counting down.
- R9: In mode 01, output mode 10 drives the pin low on an up-count match and high on a down-count match. Output mode 11 does the inverse. Output mode 01 leaves the pin unchanged.
- R10: In modes 01 and 11 a compare write goes to a buffer that reads back at address 2 at once. The buffer reaches the comparator on the tick leaving 0xFF. In modes 00 and 10 it reaches the comparator immediately.
- R11: In either PWM mode with an active compare value of 0xFF and output mode 1x, the match has no effect on the pin. Only the action at 0xFF happens: high for output mode 10, low for 11. The compare flag is still raised.
- R12: Writing control with bit 7 set and a non-PWM mode applies that write's output-mode action to the pin in the same cycle. It sets no flag, does not change the count, and bit 7 always reads as zero.
- R13: A write to the count (address 1) overrides a tick in that cycle. It also suppresses the match (flag, pin action and clear-on-compare) on the next tick.
- R14: The output enable is high when the output mode is not 00, except in a PWM mode with output mode 01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 count, 2 compare, 3 flags |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register selected by addr |
| wave_out | output | 1 | Waveform pin level |
| wave_oe | output | 1 | Waveform pin output enable |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare flag |

## Verification
The bench targets the dual-slope turn points. A design that held 0xFF or 0x00 for two ticks, or raised overflow at the top, would shift every later edge and flag from the model. It runs a compare value of 0xFF in both PWM modes. A design that did not drop the match there would leave the pin toggling instead of constant. It writes the count onto the compare value. A design that did not block the next match would set the flag or clear the count early. It also checks that a compare written mid-period in a PWM mode is read back at once but leaves the pin edges unchanged until the wrap, and that a forced compare flips the pin with no flag.

// File: rtl/timer8_pkg.sv
package timer8_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_PHASE  = 2'b01,
        MODE_CTC    = 2'b10,
        MODE_FAST   = 2'b11
    } wave_mode_e;

    typedef enum logic [1:0] {
        OUT_OFF    = 2'b00,
        OUT_TOGGLE = 2'b01,
        OUT_CLEAR  = 2'b10,
        OUT_SET    = 2'b11
    } out_mode_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_state_e;

    typedef enum logic {
        PIN_LO = 1'b0,
        PIN_HI = 1'b1
    } pin_state_e;

    typedef enum logic [1:0] {
        PIN_HOLD,
        PIN_CLEAR,
        PIN_SET,
        PIN_FLIP
    } pin_op_e;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_COUNT = 2'd1;
    localparam logic [1:0] ADDR_CMP   = 2'd2;
    localparam logic [1:0] ADDR_FLAGS = 2'd3;

    localparam int FORCE_BIT = 7;
    localparam int MODE_LSB  = 5;
    localparam int COM_LSB   = 3;
    localparam int CS_LSB    = 0;
    localparam int CTRL_W    = 7;

    function automatic logic mode_is_pwm(input wave_mode_e m);
        return (m == MODE_PHASE) || (m == MODE_FAST);
    endfunction

    function automatic pin_op_e plain_action(input out_mode_e c);
        pin_op_e op;
        unique case (c)
            OUT_OFF:    op = PIN_HOLD;
            OUT_TOGGLE: op = PIN_FLIP;
            OUT_CLEAR:  op = PIN_CLEAR;
            OUT_SET:    op = PIN_SET;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/timer8_prescale.sv
module timer8_prescale #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] clk_sel,
    output logic             tick
);
    localparam int PRE_W = 10;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    int               shift;

    always_comb begin
        unique case (clk_sel)
            3'd1:    shift = 0;
            3'd2:    shift = 3;
            3'd3:    shift = 5;
            3'd4:    shift = 6;
            3'd5:    shift = 7;
            3'd6:    shift = 8;
            default: shift = PRE_W;
        endcase
    end

    always_comb begin
        mask = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (i < shift) mask[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    assign tick = (clk_sel != '0) && ((pre_q & mask) == mask);

endmodule

// File: rtl/timer8_counter.sv
module timer8_counter
    import timer8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  wave_mode_e       mode,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt,
    output logic             tick_ok,
    output logic             match_evt,
    output logic             top_evt,
    output logic             ovf_evt,
    output logic             going_down
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_MIN = '0;

    dir_state_e       st_q, st_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             blocked_q;

    assign tick_ok    = tick && !load_en;
    assign going_down = (st_q == DIR_DOWN) && (mode == MODE_PHASE);
    assign match_evt  = tick_ok && !blocked_q && (cnt_q == cmp_val);
    assign top_evt    = tick_ok && (cnt_q == CNT_MAX);
    assign ovf_evt    = tick_ok && ((mode == MODE_PHASE) ? (going_down && cnt_q == CNT_MIN)
                                                         : (cnt_q == CNT_MAX));
    assign cnt        = cnt_q;

    // direction state machine: next-state process
    always_comb begin
        st_nx = st_q;
        if (mode != MODE_PHASE) begin
            st_nx = DIR_UP;                       // FORCE_UP
        end else if (tick_ok) begin
            unique case (st_q)
                DIR_UP:   if (cnt_q == CNT_MAX) st_nx = DIR_DOWN;  // UP_TO_DOWN
                DIR_DOWN: if (cnt_q == CNT_MIN) st_nx = DIR_UP;    // DOWN_TO_UP
            endcase
        end
    end

    // count datapath driven by the state
    always_comb begin
        cnt_nx = cnt_q;
        if (load_en) begin
            cnt_nx = load_val;
        end else if (tick_ok) begin
            if (going_down) begin
                cnt_nx = (cnt_q == CNT_MIN) ? CNT_MIN + 1'b1 : cnt_q - 1'b1;
            end else if (mode == MODE_PHASE && cnt_q == CNT_MAX) begin
                cnt_nx = CNT_MAX - 1'b1;
            end else if (mode == MODE_CTC && match_evt) begin
                cnt_nx = CNT_MIN;
            end else begin
                cnt_nx = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= DIR_UP;
            cnt_q     <= '0;
            blocked_q <= 1'b0;
        end else begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
            if (load_en)      blocked_q <= 1'b1;
            else if (tick_ok) blocked_q <= 1'b0;
        end
    end

endmodule

// File: rtl/timer8_compare.sv
module timer8_compare #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmp,
    input  logic [CNT_W-1:0] wdata,
    input  logic             pwm,
    input  logic             top_evt,
    output logic [CNT_W-1:0] cmp_active,
    output logic [CNT_W-1:0] cmp_buf,
    output logic             cmp_is_top
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] buf_q, act_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            act_q <= '0;
        end else begin
            if (wr_cmp) buf_q <= wdata;
            if (!pwm)         act_q <= wr_cmp ? wdata : buf_q;
            else if (top_evt) act_q <= buf_q;
        end
    end

    assign cmp_active = act_q;
    assign cmp_buf    = buf_q;
    assign cmp_is_top = (act_q == CNT_MAX);

endmodule

// File: rtl/timer8_wave.sv
module timer8_wave
    import timer8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  wave_mode_e mode,
    input  out_mode_e  com,
    input  logic       match_evt,
    input  logic       top_evt,
    input  logic       going_down,
    input  logic       cmp_is_top,
    input  logic       force_evt,
    input  out_mode_e  force_com,
    output logic       wave_out,
    output logic       wave_oe
);
    pin_state_e pin_q, pin_nx;
    pin_op_e    op;
    logic       hi_bit;

    assign hi_bit = com[1];

    // pin action selection per mode
    always_comb begin
        op = PIN_HOLD;
        if (force_evt) begin
            op = plain_action(force_com);
        end else begin
            unique case (mode)
                MODE_NORMAL, MODE_CTC: begin
                    if (match_evt) op = plain_action(com);
                end
                MODE_FAST: begin
                    if (top_evt && hi_bit)
                        op = (com == OUT_CLEAR) ? PIN_SET : PIN_CLEAR;
                    else if (match_evt && hi_bit && !cmp_is_top)
                        op = (com == OUT_CLEAR) ? PIN_CLEAR : PIN_SET;
                end
                MODE_PHASE: begin
                    if (top_evt && cmp_is_top && hi_bit)
                        op = (com == OUT_CLEAR) ? PIN_SET : PIN_CLEAR;
                    else if (match_evt && hi_bit && !cmp_is_top)
                        op = ((com == OUT_CLEAR) ^ going_down) ? PIN_CLEAR : PIN_SET;
                end
            endcase
        end
    end

    // pin state machine: next-state process
    always_comb begin
        pin_nx = pin_q;
        unique case (op)
            PIN_HOLD:  pin_nx = pin_q;
            PIN_CLEAR: pin_nx = PIN_LO;
            PIN_SET:   pin_nx = PIN_HI;
            PIN_FLIP:  pin_nx = (pin_q == PIN_HI) ? PIN_LO : PIN_HI;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= PIN_LO;
        else        pin_q <= pin_nx;
    end

    // output process
    always_comb begin
        wave_out = (pin_q == PIN_HI);
        wave_oe  = (com != OUT_OFF) && !(mode_is_pwm(mode) && com == OUT_TOGGLE);
    end

endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
    import timer8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    output logic             wave_out,
    output logic             wave_oe,
    output logic             ovf_flag,
    output logic             cmp_flag
);
    localparam int SEL_W = 3;

    logic [CTRL_W-1:0] ctrl_q;
    logic              ovf_q, cmpf_q;
    wave_mode_e        mode;
    out_mode_e         com;
    logic              wr_ctrl, load_en, wr_cmp, wr_flags;
    logic              tick, tick_ok, match_evt, top_evt, ovf_evt, going_down;
    logic              force_evt, cmp_is_top;
    logic [CNT_W-1:0]  cnt_q, cmp_active, cmp_buf;

    assign mode     = wave_mode_e'(ctrl_q[MODE_LSB +: 2]);
    assign com      = out_mode_e'(ctrl_q[COM_LSB +: 2]);
    assign wr_ctrl  = wr_en && (addr == ADDR_CTRL);
    assign load_en  = wr_en && (addr == ADDR_COUNT);
    assign wr_cmp   = wr_en && (addr == ADDR_CMP);
    assign wr_flags = wr_en && (addr == ADDR_FLAGS);
    assign force_evt = wr_ctrl && wdata[FORCE_BIT]
                    && !mode_is_pwm(wave_mode_e'(wdata[MODE_LSB +: 2]));

    timer8_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_sel (ctrl_q[CS_LSB +: SEL_W]),
        .tick    (tick)
    );

    timer8_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load_en    (load_en),
        .load_val   (wdata),
        .mode       (mode),
        .cmp_val    (cmp_active),
        .cnt        (cnt_q),
        .tick_ok    (tick_ok),
        .match_evt  (match_evt),
        .top_evt    (top_evt),
        .ovf_evt    (ovf_evt),
        .going_down (going_down)
    );

    timer8_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cmp     (wr_cmp),
        .wdata      (wdata),
        .pwm        (mode_is_pwm(mode)),
        .top_evt    (top_evt),
        .cmp_active (cmp_active),
        .cmp_buf    (cmp_buf),
        .cmp_is_top (cmp_is_top)
    );

    timer8_wave u_wave (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .com        (com),
        .match_evt  (match_evt),
        .top_evt    (top_evt),
        .going_down (going_down),
        .cmp_is_top (cmp_is_top),
        .force_evt  (force_evt),
        .force_com  (out_mode_e'(wdata[COM_LSB +: 2])),
        .wave_out   (wave_out),
        .wave_oe    (wave_oe)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ovf_q  <= 1'b0;
            cmpf_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
            ovf_q  <= ovf_evt   | (ovf_q  & ~(wr_flags & wdata[0]));
            cmpf_q <= match_evt | (cmpf_q & ~(wr_flags & wdata[1]));
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_CTRL:  rdata = CNT_W'(ctrl_q);
            ADDR_COUNT: rdata = cnt_q;
            ADDR_CMP:   rdata = cmp_buf;
            ADDR_FLAGS: rdata = CNT_W'({cmpf_q, ovf_q});
        endcase
    end

    assign ovf_flag = ovf_q;
    assign cmp_flag = cmpf_q;

endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk
    import timer8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [CNT_W-1:0] wdata,
    input logic             load_en,
    input logic             tick_ok,
    input logic [2:0]       cs,
    input logic [1:0]       mode,
    input logic [CNT_W-1:0] cnt,
    input logic             ovf_flag,
    input logic             cmp_flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R2
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs == 3'd0 && !load_en) |=> $stable(cnt));

    // R3
    ovf_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(cnt) == CNT_MAX || $past(cnt) == '0));

    // R5
    cmp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !(wr_en && addr == ADDR_FLAGS && wdata[1])) |=> cmp_flag);

    // R8
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_ok && mode == 2'b01) |=>
            (cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == CNT_W'($past(cnt) - 1'b1)));

    // R13
    load_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !cmp_flag) |=> !cmp_flag);

endmodule

bind pwm_timer8 pwm_timer8_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .load_en  (load_en),
    .tick_ok  (tick_ok),
    .cs       (ctrl_q[2:0]),
    .mode     (ctrl_q[6:5]),
    .cnt      (cnt_q),
    .ovf_flag (ovf_flag),
    .cmp_flag (cmp_flag)
);

// File: tb/pwm_timer8_tb.sv
`timescale 1ns/1ps
module pwm_timer8_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       wave_out, wave_oe, ovf_flag, cmp_flag;

    always #2.5 clk = ~clk;

    pwm_timer8 u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wave_out(wave_out), .wave_oe(wave_oe),
        .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string tag = "R1";

    // behavioural reference state
    logic [6:0] m_ctrl;
    int         m_cnt, m_buf, m_act, m_pre;
    bit         m_dir, m_block, m_ovf, m_cmpf, m_pin;

    task automatic check(input string t, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", t, what, act, exp, $time);
        end
    endtask

    function automatic bit plain(input int c, input bit p);
        case (c)
            1: return !p;
            2: return 1'b0;
            3: return 1'b1;
            default: return p;
        endcase
    endfunction

    always @(posedge clk) begin : model
        int  md, com, cs, dv, ncnt, nact, nbuf;
        bit  pwm, tick, load, tk, match, top, down, ovf, frc, ndir, npin;
        if (!rst_n) begin
            m_ctrl = '0; m_cnt = 0; m_buf = 0; m_act = 0; m_pre = 0;
            m_dir = 0; m_block = 0; m_ovf = 0; m_cmpf = 0; m_pin = 0;
        end else begin
            md  = m_ctrl[6:5];
            com = m_ctrl[4:3];
            cs  = m_ctrl[2:0];
            pwm = (md == 1) || (md == 3);
            dv  = (cs == 1) ? 1 : (cs == 2) ? 8 : (cs == 3) ? 32 : (cs == 4) ? 64 :
                  (cs == 5) ? 128 : (cs == 6) ? 256 : 1024;
            tick  = (cs != 0) && ((m_pre % dv) == dv - 1);
            load  = wr_en && addr == 2'd1;
            tk    = tick && !load;
            match = tk && !m_block && (m_cnt == m_act);
            top   = tk && (m_cnt == 255);
            down  = m_dir && (md == 1);
            ovf   = tk && ((md == 1) ? (down && m_cnt == 0) : (m_cnt == 255));
            frc   = wr_en && addr == 2'd0 && wdata[7] && !(wdata[5] == 1'b1);
            ncnt = m_cnt;
            if (load) ncnt = wdata;
            else if (tk) begin
                if (down)                          ncnt = (m_cnt == 0) ? 1 : m_cnt - 1;
                else if (md == 1 && m_cnt == 255)  ncnt = 254;
                else if (md == 2 && match)         ncnt = 0;
                else                               ncnt = (m_cnt + 1) % 256;
            end
            ndir = m_dir;
            if (md != 1) ndir = 0;
            else if (tk) begin
                if (!m_dir && m_cnt == 255) ndir = 1;
                else if (m_dir && m_cnt == 0) ndir = 0;
            end
            npin = m_pin;
            if (frc) npin = plain(wdata[4:3], m_pin);
            else if (md == 0 || md == 2) begin
                if (match) npin = plain(com, m_pin);
            end else if (md == 3) begin
                if (top && com >= 2) npin = (com == 2);
                else if (match && com >= 2 && m_act != 255) npin = (com == 3);
            end else begin
                if (top && m_act == 255 && com >= 2) npin = (com == 2);
                else if (match && com >= 2 && m_act != 255) npin = down ? (com == 2) : (com == 3);
            end
            nbuf = (wr_en && addr == 2'd2) ? wdata : m_buf;
            nact = m_act;
            if (!pwm) nact = (wr_en && addr == 2'd2) ? wdata : m_buf;
            else if (top) nact = m_buf;
            m_ovf  = ovf   || (m_ovf  && !(wr_en && addr == 2'd3 && wdata[0]));
            m_cmpf = match || (m_cmpf && !(wr_en && addr == 2'd3 && wdata[1]));
            if (wr_en && addr == 2'd0) m_ctrl = wdata[6:0];
            if (load) m_block = 1; else if (tk) m_block = 0;
            m_cnt = ncnt; m_dir = ndir; m_pin = npin; m_buf = nbuf; m_act = nact;
            m_pre = (m_pre + 1) % 1024;
        end
    end

    // compare against the reference every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] exp_rd;
            logic [1:0] c;
            logic [1:0] m;
            c = m_ctrl[4:3];
            m = m_ctrl[6:5];
            case (addr)
                2'd0: exp_rd = {1'b0, m_ctrl};
                2'd1: exp_rd = m_cnt[7:0];
                2'd2: exp_rd = m_buf[7:0];
                default: exp_rd = {6'd0, m_cmpf, m_ovf};
            endcase
            check(tag, "wave_out", 16'(wave_out), 16'(m_pin));
            check(tag, "wave_oe",  16'(wave_oe),  16'((c != 0) && !(m[0] && c == 2'd1)));
            check(tag, "ovf_flag", 16'(ovf_flag), 16'(m_ovf));
            check(tag, "cmp_flag", 16'(cmp_flag), 16'(m_cmpf));
            check(tag, "rdata",    16'(rdata),    16'(exp_rd));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string t);
        @(posedge clk); #1;
        addr = a;
        @(negedge clk);
        check(t, "read", 16'(rdata), 16'(exp));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog R1..: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic p;
        idle(3); #1; rst_n = 1'b1;
        // R1: reset state
        tag = "R1";
        rd(2'd0, 8'h00, "R1"); rd(2'd1, 8'h00, "R1");
        rd(2'd2, 8'h00, "R1"); rd(2'd3, 8'h00, "R1");
        @(negedge clk);
        check("R1", "wave_out", 16'(wave_out), 16'd0);
        check("R1", "wave_oe",  16'(wave_oe),  16'd0);

        // R2: stopped counter holds a written value
        tag = "R2";
        wr(2'd1, 8'h33); idle(20);
        rd(2'd1, 8'h33, "R2");

        // R3: normal wrap and overflow
        tag = "R3";
        wr(2'd1, 8'hFD); wr(2'd0, 8'h01); idle(5);
        @(negedge clk); check("R3", "ovf_flag", 16'(ovf_flag), 16'd1);
        idle(300);

        // R5: compare flag set and clear
        tag = "R5";
        wr(2'd3, 8'h03); wr(2'd2, 8'h10); idle(300);
        wr(2'd3, 8'h02); idle(40);

        // R6: non-PWM pin actions (flip, low, high)
        tag = "R6";
        wr(2'd0, 8'h09); idle(600);
        wr(2'd0, 8'h19); idle(300);
        wr(2'd0, 8'h11); idle(300);

        // R4: clear on compare
        tag = "R4";
        wr(2'd0, 8'h08); wr(2'd1, 8'h00); wr(2'd2, 8'h03); wr(2'd3, 8'h03);
        wr(2'd0, 8'h49); idle(50);
        @(negedge clk); check("R4", "ovf_flag", 16'(ovf_flag), 16'd0);

        // R12: forced compare with the counter stopped
        tag = "R12";
        wr(2'd0, 8'h08); wr(2'd3, 8'h03);
        @(negedge clk); p = wave_out;
        wr(2'd0, 8'h88);
        @(negedge clk);
        check("R12", "wave_out", 16'(wave_out), 16'(!p));
        check("R12", "cmp_flag", 16'(cmp_flag), 16'd0);
        rd(2'd0, 8'h08, "R12");
        wr(2'd0, 8'hD0); idle(4);

        // R13: count write suppresses the next match
        tag = "R13";
        wr(2'd0, 8'h00); wr(2'd2, 8'h20); wr(2'd1, 8'h20); wr(2'd3, 8'h03);
        wr(2'd1, 8'h20);
        @(posedge clk); #1; wr_en = 1'b1; addr = 2'd0; wdata = 8'h01;
        @(posedge clk); #1; wr_en = 1'b0;
        idle(10);
        @(negedge clk); check("R13", "cmp_flag", 16'(cmp_flag), 16'd0);
        idle(260);
        @(negedge clk); check("R13", "cmp_flag", 16'(cmp_flag), 16'd1);
        wr(2'd0, 8'h49); wr(2'd2, 8'h05); wr(2'd1, 8'h05); idle(300);

        // R2: prescaled rates
        tag = "R2";
        wr(2'd0, 8'h02); idle(600);
        wr(2'd0, 8'h05); idle(1500);
        wr(2'd0, 8'h07); idle(3000);
        wr(2'd0, 8'h03); idle(500);

        // R7: single-slope PWM, both polarities
        tag = "R7";
        wr(2'd2, 8'h40); wr(2'd0, 8'h71); idle(600);
        wr(2'd0, 8'h79); idle(600);

        // R10: buffered compare reads back at once
        tag = "R10";
        wr(2'd2, 8'h80);
        rd(2'd2, 8'h80, "R10");
        idle(600);

        // R14: output enable off for reserved PWM output mode
        tag = "R14";
        wr(2'd0, 8'h69);
        @(negedge clk); check("R14", "wave_oe", 16'(wave_oe), 16'd0);
        wr(2'd0, 8'h71);
        @(negedge clk); check("R14", "wave_oe", 16'(wave_oe), 16'd1);

        // R11: compare equals top in single slope
        tag = "R11";
        wr(2'd2, 8'hFF); idle(800);
        @(negedge clk); check("R11", "wave_out", 16'(wave_out), 16'd1);

        // R8 / R9: dual slope
        tag = "R8";
        wr(2'd2, 8'h40); wr(2'd0, 8'h31); wr(2'd3, 8'h03); idle(1100);
        @(negedge clk); check("R8", "ovf_flag", 16'(ovf_flag), 16'd1);
        tag = "R9";
        wr(2'd0, 8'h39); idle(1100);
        wr(2'd2, 8'h00); idle(1100);
        tag = "R11";
        wr(2'd2, 8'hFF); wr(2'd0, 8'h31); idle(1100);
        @(negedge clk); check("R11", "wave_out", 16'(wave_out), 16'd1);

        tag = "R3";
        wr(2'd0, 8'h01); idle(600);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule